// File: doc/BRIEF.md
# USB interrupt flag aggregator

This block sits between a USB device controller and an 8-bit CPU. The controller reports ten kinds of events as one-cycle pulses: an IN packet taken by the host, an OUT packet stored in either data bank, a SETUP packet, a NAK on the IN or OUT direction, a STALL handshake sent, a start of frame, a resume after suspend, and a suspend. Each pulse sets a sticky flag. Each flag has its own rules for when it may be set and how it is cleared. The bank-1 receive flag can only be set while the endpoint is double-buffered. The stalled flag is ignored on isochronous endpoints, and hardware clears it when a SETUP packet arrives.

Software uses a small register window to read the flags, clear them by writing ones, and program a per-flag mask and a control word. The control word holds a global enable, a USB enable and a 2-bit priority level. The block registers the OR of all masked pending flags, gates it with both enables, and drives it out as a single interrupt request. The priority code is driven alongside the request.

Top module: `usb_irq_collector`

## Requirements
- R1: After reset the flags, the mask and the control word are all zero, and `irq_req` is low.
- R2: A pulse on an event input sets its flag at the next clock edge. Flag bit positions, as read at register address 0, are: bit0 IN done, bit1 OUT bank 0, bit2 OUT bank 1, bit3 SETUP, bit4 NAK IN, bit5 NAK OUT, bit6 stalled, bit7 start of frame, bit8 resume, bit9 suspend.
- R3: Writing to address 0 clears every flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged. When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R4: `ev_out_b1` sets bit2 only while `cfg_pingpong` is 1. `ev_out_b0` sets bit1 whatever `cfg_pingpong` is.
- R5: The NAK flags (bits 4 and 5) stay set until software clears them. No event clears them.
- R6: `ev_stall_sent` sets bit6 only while `cfg_iso` is 0. A pulse on `ev_setup` clears bit6 at the same edge, unless a stall set counts in that same cycle.
- R7: Address 1 is the read/write mask register, one bit per flag, using the flag bit positions.
- R8: `irq_req` is high exactly when the control bits glb_en (bit0 at address 2) and usb_en (bit1) are both 1 and, at the previous clock edge, at least one flag was set with its mask bit set. A flag set at edge k can therefore raise `irq_req` no earlier than edge k+1.
- R9: Address 2 holds the control word {level[1:0] at bits 3:2, usb_en at bit1, glb_en at bit0}. `irq_level` always equals bits 3:2, where 00 is the lowest level and 11 the highest.
- R10: Reading address 3 returns zero, and every bit above the defined fields reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_in_done | input | 1 | Host accepted an IN packet |
| ev_out_b0 | input | 1 | OUT packet stored in bank 0 |
| ev_out_b1 | input | 1 | OUT packet stored in bank 1 |
| ev_setup | input | 1 | SETUP packet accepted |
| ev_nak_in | input | 1 | NAK handshake on IN |
| ev_nak_out | input | 1 | NAK handshake on OUT |
| ev_stall_sent | input | 1 | STALL handshake sent on request |
| ev_sof | input | 1 | Start of frame received |
| ev_resume | input | 1 | Resume detected after suspend |
| ev_suspend | input | 1 | Suspend detected |
| cfg_pingpong | input | 1 | Endpoint is double-buffered |
| cfg_iso | input | 1 | Endpoint is isochronous |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for `reg_addr` (combinational) |
| irq_req | output | 1 | Gated interrupt request |
| irq_level | output | 2 | Priority code {high, low} |

## Verification
Assertions check the per-cycle rules on every cycle. These are: a set beats a clear, a flag holds while no clear is present, bank 1 needs ping-pong mode, a stall needs a non-isochronous endpoint, SETUP clears the stall flag, the mask write lands, and the request follows pending state and enables. The bench's scenarios cover the rest. They show the one-cycle latency from event to request, the gating by each enable on its own, NAK flags that persist across idle cycles, and the exact read-back map. They also include a long random mix of events and register writes, compared against an independent model.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int NFLAG  = 10;
  localparam int CTRL_W = 4;

  localparam int F_IN_DONE = 0;
  localparam int F_OUT_B0  = 1;
  localparam int F_OUT_B1  = 2;
  localparam int F_SETUP   = 3;
  localparam int F_NAK_IN  = 4;
  localparam int F_NAK_OUT = 5;
  localparam int F_STALL   = 6;
  localparam int F_SOF     = 7;
  localparam int F_RESUME  = 8;
  localparam int F_SUSPEND = 9;

  typedef enum logic [1:0] {
    SEL_FLAGS = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [1:0] level;
    logic       usb_en;
    logic       glb_en;
  } ctrl_t;

  // sticky flag update: a set always beats a clear
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic any_pending(input logic [NFLAG-1:0] f, input logic [NFLAG-1:0] m);
    return |(f & m);
  endfunction

  function automatic logic gate_req(input logic pend, input ctrl_t c);
    return pend & c.glb_en & c.usb_en;
  endfunction
endpackage

// File: rtl/usb_irq_flag_cell.sv
module usb_irq_flag_cell
  import usb_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= flag_next(q, hw_set, clr);
  end

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> q);

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clr) |=> q);
endmodule

// File: rtl/usb_irq_flag_bank.sv
module usb_irq_flag_bank
  import usb_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] ev,
  input  logic             cfg_pingpong,
  input  logic             cfg_iso,
  input  logic [NFLAG-1:0] sw_clr,
  output logic [NFLAG-1:0] flags
);
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] hw_clr_vec;

  always_comb begin
    set_vec           = ev;
    set_vec[F_OUT_B1] = ev[F_OUT_B1] & cfg_pingpong;
    set_vec[F_STALL]  = ev[F_STALL] & ~cfg_iso;
    hw_clr_vec        = '0;
    hw_clr_vec[F_STALL] = ev[F_SETUP];
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_cell
    usb_irq_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_set (set_vec[i]),
      .clr    (sw_clr[i] | hw_clr_vec[i]),
      .q      (flags[i])
    );
  end

  // R4
  b1_needs_pp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[F_OUT_B1]) |-> $past(cfg_pingpong));

  // R6
  stall_not_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[F_STALL]) |-> !$past(cfg_iso));

  // R6
  stall_setup_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[F_SETUP] && !(ev[F_STALL] && !cfg_iso)) |=> !flags[F_STALL]);
endmodule

// File: rtl/usb_irq_regs.sv
module usb_irq_regs
  import usb_irq_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic [NFLAG-1:0] flags,
  output logic [NFLAG-1:0] mask,
  output ctrl_t            ctrl,
  output logic [NFLAG-1:0] sw_clr,
  output logic [REG_W-1:0] reg_rdata
);
  reg_sel_e sel;
  logic     wr_mask, wr_ctrl;
  logic     unused_wdata;

  assign sel          = reg_sel_e'(reg_addr);
  assign wr_mask      = reg_wr && (sel == SEL_MASK);
  assign wr_ctrl      = reg_wr && (sel == SEL_CTRL);
  assign sw_clr       = (reg_wr && (sel == SEL_FLAGS)) ? reg_wdata[NFLAG-1:0] : '0;
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
      ctrl <= '0;
    end else begin
      if (wr_mask) mask <= reg_wdata[NFLAG-1:0];
      if (wr_ctrl) ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_FLAGS: reg_rdata[NFLAG-1:0]  = flags;
      SEL_MASK:  reg_rdata[NFLAG-1:0]  = mask;
      SEL_CTRL:  reg_rdata[CTRL_W-1:0] = ctrl;
      default:   reg_rdata = '0;
    endcase
  end

  // R7
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask == $past(reg_wdata[NFLAG-1:0])));

  // R9
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl));
endmodule

// File: rtl/usb_irq_req.sv
module usb_irq_req
  import usb_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] flags,
  input  logic [NFLAG-1:0] mask,
  input  ctrl_t            ctrl,
  output logic             irq_req,
  output logic [1:0]       irq_level
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= any_pending(flags, mask);
  end

  assign irq_req   = gate_req(pend_q, ctrl);
  assign irq_level = ctrl.level;

  // R8
  req_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(|(flags & mask)) && ctrl.glb_en && ctrl.usb_en) |-> irq_req);

  // R8
  req_no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flags & mask)) |=> !irq_req);
endmodule

// File: rtl/usb_irq_collector.sv
module usb_irq_collector
  import usb_irq_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_in_done,
  input  logic             ev_out_b0,
  input  logic             ev_out_b1,
  input  logic             ev_setup,
  input  logic             ev_nak_in,
  input  logic             ev_nak_out,
  input  logic             ev_stall_sent,
  input  logic             ev_sof,
  input  logic             ev_resume,
  input  logic             ev_suspend,
  input  logic             cfg_pingpong,
  input  logic             cfg_iso,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq_req,
  output logic [1:0]       irq_level
);
  logic [NFLAG-1:0] ev_vec;
  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] mask;
  logic [NFLAG-1:0] sw_clr;
  ctrl_t            ctrl;

  always_comb begin
    ev_vec            = '0;
    ev_vec[F_IN_DONE] = ev_in_done;
    ev_vec[F_OUT_B0]  = ev_out_b0;
    ev_vec[F_OUT_B1]  = ev_out_b1;
    ev_vec[F_SETUP]   = ev_setup;
    ev_vec[F_NAK_IN]  = ev_nak_in;
    ev_vec[F_NAK_OUT] = ev_nak_out;
    ev_vec[F_STALL]   = ev_stall_sent;
    ev_vec[F_SOF]     = ev_sof;
    ev_vec[F_RESUME]  = ev_resume;
    ev_vec[F_SUSPEND] = ev_suspend;
  end

  usb_irq_flag_bank u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev           (ev_vec),
    .cfg_pingpong (cfg_pingpong),
    .cfg_iso      (cfg_iso),
    .sw_clr       (sw_clr),
    .flags        (flags)
  );

  usb_irq_regs #(.REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .flags     (flags),
    .mask      (mask),
    .ctrl      (ctrl),
    .sw_clr    (sw_clr),
    .reg_rdata (reg_rdata)
  );

  usb_irq_req u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags     (flags),
    .mask      (mask),
    .ctrl      (ctrl),
    .irq_req   (irq_req),
    .irq_level (irq_level)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!irq_req && flags == '0 && mask == '0));

  // R2
  sof_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sof |=> flags[F_SOF]);
endmodule

// File: tb/sim_usb_irq_collector.sv
module sim_usb_irq_collector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] ev = '0;
  logic pp = 1'b0, iso = 1'b0;
  logic [1:0] addr = '0;
  logic wr = 1'b0;
  logic [15:0] wd = '0;
  logic [15:0] rd;
  logic irq;
  logic [1:0] lvl;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [9:0] m_flags = '0, m_mask = '0;
  logic [3:0] m_ctrl = '0;
  logic       m_pend = 1'b0;

  always #5 clk = ~clk;

  usb_irq_collector u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_in_done(ev[0]), .ev_out_b0(ev[1]), .ev_out_b1(ev[2]), .ev_setup(ev[3]),
    .ev_nak_in(ev[4]), .ev_nak_out(ev[5]), .ev_stall_sent(ev[6]), .ev_sof(ev[7]),
    .ev_resume(ev[8]), .ev_suspend(ev[9]),
    .cfg_pingpong(pp), .cfg_iso(iso),
    .reg_addr(addr), .reg_wr(wr), .reg_wdata(wd), .reg_rdata(rd),
    .irq_req(irq), .irq_level(lvl)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not end (actual %0d cycles, expected fewer)", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] m_next(input logic [9:0] f, input logic [9:0] e,
                                        input logic p, input logic i, input logic w,
                                        input logic [1:0] a, input logic [15:0] d);
    logic [9:0] s, c;
    s = e;
    if (!p) s[2] = 1'b0;
    if (i)  s[6] = 1'b0;
    c = (w && a == 2'd0) ? d[9:0] : 10'd0;
    if (e[3]) c[6] = 1'b1;
    return s | (f & ~c);
  endfunction

  function automatic logic [15:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {6'd0, m_flags};
      2'd1: return {6'd0, m_mask};
      2'd2: return {12'd0, m_ctrl};
      default: return 16'd0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [1:0] a);
    case (a)
      2'd0: return "R2 flag read";
      2'd1: return "R7 mask read";
      2'd2: return "R9 ctrl read";
      default: return "R10 empty read";
    endcase
  endfunction

  // called at a negedge; returns at the next negedge
  task automatic cycle(input logic [9:0] e, input logic p, input logic i,
                       input logic w, input logic [1:0] a, input logic [15:0] d);
    logic np;
    ev = e; pp = p; iso = i; wr = w; addr = a; wd = d;
    #1;
    check(rd_tag(a), rd, m_read(a));
    @(posedge clk);
    np = |(m_flags & m_mask);
    m_flags = m_next(m_flags, e, p, i, w, a, d);
    if (w && a == 2'd1) m_mask = d[9:0];
    if (w && a == 2'd2) m_ctrl = d[3:0];
    m_pend = np;
    @(negedge clk);
    ev = '0; wr = 1'b0;
    check("R8 irq_req", {15'd0, irq}, {15'd0, m_pend & m_ctrl[0] & m_ctrl[1]});
    check("R9 irq_level", {14'd0, lvl}, {14'd0, m_ctrl[3:2]});
  endtask

  task automatic idle();
    cycle('0, pp, iso, 1'b0, 2'd3, 16'd0);
  endtask

  task automatic peek(input logic [1:0] a, input logic [15:0] exp, input string tag);
    addr = a; wr = 1'b0;
    #1;
    check(tag, rd, exp);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    peek(2'd0, 16'h0000, "R1 flags after reset");
    peek(2'd1, 16'h0000, "R1 mask after reset");
    peek(2'd2, 16'h0000, "R1 ctrl after reset");
    check("R1 irq after reset", {15'd0, irq}, 16'd0);
    peek(2'd3, 16'h0000, "R10 address 3");

    // full mask, both enables, level 0
    cycle('0, 1'b0, 1'b0, 1'b1, 2'd1, 16'hFFFF);
    peek(2'd1, 16'h03FF, "R7 mask keeps only flag bits / R10 upper zero");
    cycle('0, 1'b0, 1'b0, 1'b1, 2'd2, 16'h0003);

    // R8 latency: SOF at edge k, request after edge k+1
    cycle(10'h080, 1'b0, 1'b0, 1'b0, 2'd3, 16'd0);
    check("R8 no request in the event cycle", {15'd0, irq}, 16'd0);
    peek(2'd0, 16'h0080, "R2 SOF flag bit7");
    idle();
    check("R8 request one cycle later", {15'd0, irq}, 16'd1);
    cycle('0, 1'b0, 1'b0, 1'b1, 2'd0, 16'h0080);
    idle();
    check("R8 request drops after clear", {15'd0, irq}, 16'd0);

    // R3 set beats clear; R5 NAK flags persist
    cycle(10'h010, 1'b0, 1'b0, 1'b1, 2'd0, 16'h0010);
    peek(2'd0, 16'h0010, "R3 set wins over same-cycle clear");
    repeat (5) cycle(10'h100, 1'b0, 1'b0, 1'b0, 2'd3, 16'd0);
    peek(2'd0, 16'h0110, "R5 NAK IN stays set");
    cycle('0, 1'b0, 1'b0, 1'b1, 2'd0, 16'h0100);
    peek(2'd0, 16'h0010, "R3 write zero bits untouched");
    cycle('0, 1'b0, 1'b0, 1'b1, 2'd0, 16'h0010);
    peek(2'd0, 16'h0000, "R3 NAK IN cleared");

    // R4 bank 1 needs ping-pong
    cycle(10'h006, 1'b0, 1'b0, 1'b0, 2'd3, 16'd0);
    peek(2'd0, 16'h0002, "R4 bank1 ignored without pingpong");
    cycle(10'h004, 1'b1, 1'b0, 1'b0, 2'd3, 16'd0);
    peek(2'd0, 16'h0006, "R4 bank1 set with pingpong");
    cycle('0, 1'b0, 1'b0, 1'b1, 2'd0, 16'h03FF);

    // R6 stall rules
    cycle(10'h040, 1'b0, 1'b1, 1'b0, 2'd3, 16'd0);
    peek(2'd0, 16'h0000, "R6 stall ignored on iso");
    cycle(10'h040, 1'b0, 1'b0, 1'b0, 2'd3, 16'd0);
    peek(2'd0, 16'h0040, "R6 stall set");
    cycle(10'h008, 1'b0, 1'b0, 1'b0, 2'd3, 16'd0);
    peek(2'd0, 16'h0008, "R6 setup clears stall");
    cycle(10'h048, 1'b0, 1'b0, 1'b0, 2'd3, 16'd0);
    peek(2'd0, 16'h0048, "R6 stall set beats setup clear");

    // R8 each enable alone, R9 level
    cycle('0, 1'b0, 1'b0, 1'b1, 2'd2, 16'h0009);
    idle();
    check("R8 usb_en low gates request", {15'd0, irq}, 16'd0);
    check("R9 level 2", {14'd0, lvl}, 16'd2);
    cycle('0, 1'b0, 1'b0, 1'b1, 2'd2, 16'h000E);
    check("R8 glb_en low gates request", {15'd0, irq}, 16'd0);
    check("R9 level 3", {14'd0, lvl}, 16'd3);
    cycle('0, 1'b0, 1'b0, 1'b1, 2'd2, 16'h0003);
    check("R8 both enables", {15'd0, irq}, 16'd1);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [9:0] e;
      logic w;
      logic [15:0] d;
      for (int b = 0; b < 10; b++) e[b] = ($urandom % 6) == 0;
      w = ($urandom % 3) == 0;
      d = 16'($urandom);
      if (($urandom % 4) != 0) d[1:0] = 2'b11;
      cycle(e, 1'($urandom % 2), ($urandom % 4) == 0, w, 2'($urandom % 4), d);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule